// File: doc/BRIEF.md
# Debounced Multi-Source Wake-Up Controller

This block decides when the sleeping core must be woken. Everything runs on the slow clock. It watches an active-low force-wake pin, a bank of general wake inputs, two alarm lines (a periodic timer and a calendar), and a supply-monitor detection line. When any enabled source qualifies, it raises a one-cycle wake request. The supply switch that acts on that request lies outside the block.

Each general input has its own enable and its own active level. The general inputs share one debounce length, and the force-wake pin has a separate one. Both lengths come from a fixed ladder: 1 (immediate), 3, 32, 512, 4096 or 32768 slow-clock edges. The block keeps sticky flags that record whether the force pin or the general bank woke the core, and these flags clear when the status word is read. When the general debouncer fires, the block also takes a snapshot of which enabled inputs were active at that moment.

Configuration comes in two static words. The mode word holds the source enables and the two debounce codes. The input word holds the per-input enables in bits N-1:0 and the per-input levels in bits 2N-1:N. Inputs are assumed to be synchronous to the slow clock already.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, `wake_req` is 0, and status bits 0, 1 and 31:16 are 0.
- R2: The force pin is active low and is enabled by mode bit 0. When mode bit 0 is clear, the force pin never raises `wake_req`.
- R3: The debounce codes are held in mode bits 10:8 (force pin) and 14:12 (general bank). Codes 0 to 5 require 1, 3, 32, 512, 4096 or 32768 consecutive slow-clock edges of activity. Codes 6 and 7 behave like code 5. A single inactive edge restarts the count.
- R4: Input-word bit i enables general input i. Input-word bit N+i selects its level: 0 means input i is active when low, 1 means active when high. A disabled input never contributes.
- R5: The general bank has one shared counter. It advances while at least one enabled input is active, even when the active input changes from one to another, and it restarts when no enabled input is active.
- R6: After a debouncer fires, that source cannot fire again until it has been inactive for at least one edge. Holding an input active therefore yields exactly one wake.
- R7: A rising edge of an alarm or monitor line raises `wake_req`, provided that line is enabled. The enables are mode bit 1 (supply monitor), bit 2 (timer) and bit 3 (calendar). A line that stays high wakes only once.
- R8: `wake_req` is high for exactly the one cycle after the edge at which a source qualifies, and it is never high without such a source.
- R9: Status bit 0 is set by a force-pin wake and status bit 1 by a general-bank wake. The edge at which `stat_rd` is high clears both bits, but a set on that same edge wins over the clear.
- R10: Status bits 16+i capture, on a general-bank wake, whether input i was both enabled and active. The snapshot holds until the next general-bank wake and is not cleared by reads.
- R11: Status bit 12 follows the live force pin. Bits 2 to 11 and 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 16 | Source enables and debounce codes |
| in_cfg | input | 2*N_IN | Per-input enables (low half) and levels (high half) |
| force_n | input | 1 | Force-wake pin, active low |
| wake_in | input | N_IN | General wake inputs |
| smon_det | input | 1 | Supply-monitor detection |
| timer_alarm | input | 1 | Periodic timer alarm |
| cal_alarm | input | 1 | Calendar alarm |
| stat_rd | input | 1 | Status read strobe (clears the sticky flags) |
| wake_req | output | 1 | One-cycle core wake request |
| status | output | 16+N_IN | Flags, live pin level and input snapshot |

## Verification
The hardest cases to reach are those that exercise the shared counter's memory. The first is a count carried across a hand-over from one active input to another. The second is a count restarted by a one-edge gap. The third is a fire followed by an input that stays active and must stay locked out. The stimulus drives these as exact edge-by-edge sequences at the pins, and it measures the latency to `wake_req` against the ladder value. The highest ladder step (code 7) and a read strobe placed on the very edge where a wake sets a flag are also driven directly.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // Top of the debounce ladder and counter width derived from it
  localparam int unsigned DBC_TOP = 32768;
  localparam int CNT_W = $clog2(DBC_TOP + 1);

  // Mode word layout
  localparam int M_FORCE_EN = 0;
  localparam int M_SMON_EN  = 1;
  localparam int M_TIMER_EN = 2;
  localparam int M_CAL_EN   = 3;
  localparam int M_FDBC_LSB = 8;
  localparam int M_GDBC_LSB = 12;

  // Status word layout
  localparam int S_FORCE   = 0;
  localparam int S_GEN     = 1;
  localparam int S_PIN     = 12;
  localparam int S_CAP_LSB = 16;

  typedef struct packed {
    logic       force_en;
    logic       smon_en;
    logic       timer_en;
    logic       cal_en;
    logic [2:0] fcode;
    logic [2:0] gcode;
  } mode_t;

  function automatic mode_t decode_mode(input logic [15:0] w);
    mode_t m;
    m.force_en = w[M_FORCE_EN];
    m.smon_en  = w[M_SMON_EN];
    m.timer_en = w[M_TIMER_EN];
    m.cal_en   = w[M_CAL_EN];
    m.fcode    = w[M_FDBC_LSB +: 3];
    m.gcode    = w[M_GDBC_LSB +: 3];
    return m;
  endfunction

  // Number of consecutive active edges needed for a given code
  function automatic logic [CNT_W-1:0] dbc_len(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(1);
      3'd1:    return CNT_W'(3);
      3'd2:    return CNT_W'(32);
      3'd3:    return CNT_W'(512);
      3'd4:    return CNT_W'(4096);
      default: return CNT_W'(DBC_TOP);
    endcase
  endfunction
endpackage

// File: rtl/wake_debounce.sv
module wake_debounce
  import wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] len,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  // Qualifies on this edge once the run reaches the programmed length
  assign fire = active & armed & (cnt_next >= {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (!active) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      if (fire) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt_next[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] en,
  output logic [N_SRC-1:0] ev
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic gated;
    logic prev;
    assign gated = src[i] & en[i];
    assign ev[i] = gated & ~prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= gated;
    end
  end
endmodule

// File: rtl/wake_status.sv
module wake_status #(
  parameter int N_IN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic            set_force,
  input  logic            set_gen,
  input  logic [N_IN-1:0] act_vec,
  output logic            flag_force,
  output logic            flag_gen,
  output logic [N_IN-1:0] cap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_force <= 1'b0;
      flag_gen   <= 1'b0;
      cap        <= '0;
    end else begin
      if (set_force) flag_force <= 1'b1;
      else if (rd)   flag_force <= 1'b0;
      if (set_gen)   flag_gen <= 1'b1;
      else if (rd)   flag_gen <= 1'b0;
      if (set_gen)   cap <= act_vec;
    end
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int N_IN = 16,
  localparam int ST_W = S_CAP_LSB + N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       mode_cfg,
  input  logic [2*N_IN-1:0] in_cfg,
  input  logic              force_n,
  input  logic [N_IN-1:0]   wake_in,
  input  logic              smon_det,
  input  logic              timer_alarm,
  input  logic              cal_alarm,
  input  logic              stat_rd,
  output logic              wake_req,
  output logic [ST_W-1:0]   status
);
  mode_t           mode;
  logic [N_IN-1:0] in_en;
  logic [N_IN-1:0] in_pol;
  logic [N_IN-1:0] gen_act;
  logic            force_act;
  logic            force_fire;
  logic            gen_fire;
  logic [2:0]      alarm_ev;
  logic            flag_force;
  logic            flag_gen;
  logic [N_IN-1:0] cap;
  logic            unused_mode_bits;

  assign mode             = decode_mode(mode_cfg);
  assign unused_mode_bits = ^{mode_cfg[7:4], mode_cfg[11], mode_cfg[15]};
  assign in_en            = in_cfg[N_IN-1:0];
  assign in_pol           = in_cfg[2*N_IN-1:N_IN];
  // An input is active when its level matches its polarity bit
  assign gen_act          = in_en & ~(wake_in ^ in_pol);
  assign force_act        = mode.force_en & ~force_n;

  wake_debounce u_force_dbc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (force_act),
    .len    (dbc_len(mode.fcode)),
    .fire   (force_fire)
  );

  wake_debounce u_gen_dbc (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (|gen_act),
    .len    (dbc_len(mode.gcode)),
    .fire   (gen_fire)
  );

  wake_edge #(.N_SRC(3)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .src   ({cal_alarm, timer_alarm, smon_det}),
    .en    ({mode.cal_en, mode.timer_en, mode.smon_en}),
    .ev    (alarm_ev)
  );

  wake_status #(.N_IN(N_IN)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (stat_rd),
    .set_force  (force_fire),
    .set_gen    (gen_fire),
    .act_vec    (gen_act),
    .flag_force (flag_force),
    .flag_gen   (flag_gen),
    .cap        (cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= force_fire | gen_fire | (|alarm_ev);
  end

  always_comb begin
    status                     = '0;
    status[S_FORCE]            = flag_force;
    status[S_GEN]              = flag_gen;
    status[S_PIN]              = force_n;
    status[S_CAP_LSB +: N_IN]  = cap;
  end
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
  parameter int N_IN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*N_IN-1:0] in_cfg,
  input logic              stat_rd,
  input logic              wake_req,
  input logic [16+N_IN-1:0] status,
  input logic              force_fire,
  input logic              gen_fire,
  input logic [2:0]        alarm_ev,
  input logic [N_IN-1:0]   gen_act
);
  logic any_src;
  assign any_src = force_fire | gen_fire | (|alarm_ev);

  assert_force_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_fire |=> !force_fire);

  assert_gen_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gen_fire |=> !gen_fire);

  assert_req_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> wake_req);

  assert_req_needs_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_src |=> !wake_req);

  assert_force_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_fire |=> status[0]);

  assert_gen_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gen_fire |=> status[1]);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !gen_fire) |=> !status[1]);

  assert_cap_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gen_fire |=> ((status[16 +: N_IN] & ~$past(in_cfg[N_IN-1:0])) == '0));

  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_fire |=> $stable(status[16 +: N_IN]));

  assert_fire_needs_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_fire |-> (|gen_act));
endmodule

bind wake_ctrl wake_ctrl_chk #(.N_IN(N_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_cfg     (in_cfg),
  .stat_rd    (stat_rd),
  .wake_req   (wake_req),
  .status     (status),
  .force_fire (force_fire),
  .gen_fire   (gen_fire),
  .alarm_ev   (alarm_ev),
  .gen_act    (gen_act)
);

// File: tb/wake_ctrl_test.sv
module wake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mode_cfg;
  logic [31:0] in_cfg;
  logic        force_n;
  logic [15:0] wake_in;
  logic        smon_det, timer_alarm, cal_alarm, stat_rd;
  logic        wake_req;
  logic [31:0] status;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .in_cfg(in_cfg),
    .force_n(force_n), .wake_in(wake_in), .smon_det(smon_det),
    .timer_alarm(timer_alarm), .cal_alarm(cal_alarm), .stat_rd(stat_rd),
    .wake_req(wake_req), .status(status)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [15:0] en;
    logic [15:0] pol;
    logic [15:0] act;
    logic [31:0] lat;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 16'h0001, 16'h0000, 16'h0001, 32'd1},
    '{3'd1, 16'h00F0, 16'h00F0, 16'h0030, 32'd3},
    '{3'd2, 16'hFFFF, 16'hAAAA, 16'h8001, 32'd32},
    '{3'd1, 16'h0F00, 16'h0000, 16'h1100, 32'd3},
    '{3'd3, 16'h8000, 16'h8000, 16'h8000, 32'd512}
  };

  function automatic logic [15:0] mk_mode(input logic fen, sen, ten, cen,
                                          input logic [2:0] fc, gc);
    return {1'b0, gc, 1'b0, fc, 4'b0000, cen, ten, sen, fen};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_wake(input int limit, output int lat);
    lat = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wake_req) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wake_req) seen++;
    end
  endtask

  task automatic rd_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, seen;
    rst_n = 1'b0; mode_cfg = '0; in_cfg = '0; force_n = 1'b1; wake_in = '0;
    smon_det = 1'b0; timer_alarm = 1'b0; cal_alarm = 1'b0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: reset state, live pin high
    chk("R1 wake_req", {31'd0, wake_req}, 32'd0);
    chk("R1 status", status, 32'h0000_1000);

    // R2 disabled force pin, R11 live level
    force_n = 1'b0;
    quiet(6, seen);
    chk("R2 disabled pin no wake", seen, 0);
    chk("R11 live pin low", {31'd0, status[12]}, 32'd0);
    force_n = 1'b1;
    @(negedge clk);

    // R2/R3 force pin, code 1
    mode_cfg = mk_mode(1, 0, 0, 0, 3'd1, 3'd0);
    @(negedge clk);
    force_n = 1'b0;
    wait_wake(50, lat);
    chk("R3 force code1 latency", lat, 3);
    chk("R9 force flag set", {31'd0, status[0]}, 32'd1);
    @(negedge clk);
    chk("R8 one-cycle pulse", {31'd0, wake_req}, 32'd0);
    quiet(10, seen);
    chk("R6 force held no retrigger", seen, 0);
    force_n = 1'b1;
    @(negedge clk);
    rd_status();
    chk("R9 force flag cleared", {31'd0, status[0]}, 32'd0);

    // R3 restart on a short glitch
    force_n = 1'b0;
    quiet(2, seen);
    force_n = 1'b1;
    begin
      int s2;
      quiet(1, s2);
      seen += s2;
    end
    chk("R3 short low ignored", seen, 0);
    force_n = 1'b0;
    wait_wake(50, lat);
    chk("R3 count restarted", lat, 3);
    force_n = 1'b1;
    @(negedge clk);
    rd_status();

    // R9 set wins over read on the same edge (code 0)
    mode_cfg = mk_mode(1, 0, 0, 0, 3'd0, 3'd0);
    @(negedge clk);
    force_n = 1'b0;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R3 code0 immediate", {31'd0, wake_req}, 32'd1);
    chk("R9 set beats read", {31'd0, status[0]}, 32'd1);
    force_n = 1'b1;
    @(negedge clk);
    rd_status();

    // R3 code 7 behaves like 32768
    mode_cfg = mk_mode(1, 0, 0, 0, 3'd7, 3'd0);
    @(negedge clk);
    force_n = 1'b0;
    wait_wake(40000, lat);
    chk("R3 code7 latency", lat, 32768);
    force_n = 1'b1;
    mode_cfg = '0;
    @(negedge clk);
    rd_status();

    // R4/R3/R10 table of general-input cases
    for (int k = 0; k < NV; k++) begin
      mode_cfg = mk_mode(0, 0, 0, 0, 3'd0, VEC[k].code);
      in_cfg   = {VEC[k].pol, VEC[k].en};
      wake_in  = ~VEC[k].pol;
      @(negedge clk);
      @(negedge clk);
      rd_status();
      wake_in = ~(VEC[k].act ^ VEC[k].pol);
      wait_wake(1000, lat);
      chk($sformatf("R4 vec%0d latency", k), lat, VEC[k].lat);
      chk($sformatf("R10 vec%0d capture", k), {16'd0, status[31:16]},
          {16'd0, VEC[k].act & VEC[k].en});
      chk($sformatf("R9 vec%0d gen flag", k), {31'd0, status[1]}, 32'd1);
      wake_in = ~VEC[k].pol;
      @(negedge clk);
    end

    // R4 disabled input alone has no effect
    mode_cfg = mk_mode(0, 0, 0, 0, 3'd0, 3'd0);
    in_cfg   = {16'h0000, 16'h0001};
    wake_in  = 16'hFFFF;
    @(negedge clk);
    wake_in  = 16'hFFDF;
    quiet(8, seen);
    chk("R4 disabled input ignored", seen, 0);

    // R5 hand-over keeps counting (code 1, inputs 0 and 1 active high)
    mode_cfg = mk_mode(0, 0, 0, 0, 3'd0, 3'd1);
    in_cfg   = {16'h0003, 16'h0003};
    wake_in  = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    wake_in = 16'h0001;
    quiet(2, seen);
    chk("R5 two edges no wake", seen, 0);
    wake_in = 16'h0002;
    wait_wake(20, lat);
    chk("R5 hand-over continues", lat, 1);
    chk("R10 capture after hand-over", {16'd0, status[31:16]}, 32'h0002);

    // R6 held input locked out, then re-armed after a gap
    quiet(10, seen);
    chk("R6 gen held no retrigger", seen, 0);
    wake_in = 16'h0000;
    @(negedge clk);
    wake_in = 16'h0002;
    wait_wake(20, lat);
    chk("R6 re-armed after gap", lat, 3);

    // R10 capture survives read and input changes
    rd_status();
    wake_in = 16'h0003;
    quiet(4, seen);
    chk("R10 capture held", {16'd0, status[31:16]}, 32'h0002);
    chk("R9 gen flag cleared", {31'd0, status[1]}, 32'd0);

    // R5 gap restarts the count
    wake_in = 16'h0000;
    @(negedge clk);
    wake_in = 16'h0001;
    quiet(2, seen);
    wake_in = 16'h0000;
    @(negedge clk);
    wake_in = 16'h0002;
    wait_wake(20, lat);
    chk("R5 gap restarts", lat + seen, 3);
    wake_in = 16'h0000;
    in_cfg  = '0;
    @(negedge clk);

    // R7 alarms and monitor
    mode_cfg = mk_mode(0, 0, 1, 0, 3'd0, 3'd0);
    @(negedge clk);
    timer_alarm = 1'b1;
    wait_wake(5, lat);
    chk("R7 timer edge", lat, 1);
    quiet(5, seen);
    chk("R7 timer held once", seen, 0);
    timer_alarm = 1'b0;
    cal_alarm   = 1'b1;
    quiet(5, seen);
    chk("R7 calendar disabled", seen, 0);
    cal_alarm = 1'b0;
    mode_cfg  = mk_mode(0, 1, 0, 0, 3'd0, 3'd0);
    @(negedge clk);
    smon_det = 1'b1;
    wait_wake(5, lat);
    chk("R7 monitor edge", lat, 1);
    smon_det = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule